// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of peripheral request lines and a processor core. A rising edge on a request line makes that source pending, and the source stays pending until the processor takes its vector. Software can block each ordinary source with a mask bit. A global enable gates all ordinary sources together. Source 0 is a non-maskable line that ignores both controls.

Among the pending sources that are allowed through, the lowest index wins. The block raises a single interrupt line to the core only when the winner outranks every level already in service. The core answers with a one-clock acknowledge. On the next clock the block presents a one-clock vector strobe with the vector number and the vector address, which is the number times four. In that same acknowledge cycle the block clears the winner's pending flag and marks its level as in service.

Levels in service are held as one bit per source, so nested handlers unwind in order. Each return-from-interrupt pulse retires the highest-priority level in service. Only a strictly higher priority can nest on top of the levels in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_int` and `vec_valid` are low, nothing is pending or in service, and `mask_rdata` reads all ones, so every ordinary source starts masked.
- R2: A rising edge on `irq_line[i]` sets pending for source i. Pending stays set after the line falls. A line held high across its acknowledge does not set pending again.
- R3: Ordinary source i (i ≥ 1) with mask bit i = 1 is never forwarded; a lower-priority unmasked source is served instead.
- R4: Source 0 is non-maskable. It is forwarded whatever `mask` bit 0 or `glb_en` hold, and it ranks above every other source.
- R5: While `glb_en` is low, sources 1 to N_SRC-1 are not forwarded.
- R6: Of the sources that are pending and allowed through, the one with the lowest index is granted.
- R7: The vector number is VEC_BASE + index, and the vector address is the vector number times 4. With VEC_BASE = 32, source 3 gives number 35 and address 0x08C. Both are valid during the single clock where `vec_valid` is high, one clock after the acknowledge.
- R8: The granted source's pending flag is cleared at the acknowledge edge, so a later acknowledge without a new edge does not serve it again.
- R9: `cpu_int` is high one clock after any allowed pending source outranks the highest-priority level in service. A pending source of equal or lower priority waits.
- R10: A pulse on `rti` retires the highest-priority level in service, which restores the level that was interrupted.
- R11: An acknowledge with no allowed pending source that outranks the level in service produces no vector strobe and changes no state.
- R12: A write with `mask_we` high stores `mask_wdata`, and `mask_rdata` returns it from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | N_SRC | Request lines, index 0 non-maskable and highest priority |
| glb_en | input | 1 | Global enable for ordinary sources |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | N_SRC | Mask write data, 1 = source blocked |
| mask_rdata | output | N_SRC | Mask read data |
| int_ack | input | 1 | One-clock acknowledge from the core |
| rti | input | 1 | One-clock return-from-interrupt pulse |
| cpu_int | output | 1 | Interrupt request to the core |
| vec_valid | output | 1 | One-clock vector strobe |
| vec_num | output | VEC_W | Vector number |
| vec_addr | output | VEC_W+2 | Vector address (number times 4) |

## Verification
The assertions check on every cycle that the non-maskable source drives the interrupt line whenever it is pending and not already in service. They also check that the global enable silences the line when only ordinary sources are pending, and that a vector strobe only ever follows an acknowledge. Three more cycle checks cover the pending flag, which drops after its grant, the return pulse, which removes exactly one level, and the mask readback. The choice of winner among mixed masked and unmasked patterns, the exact vector values, and the order of a nested sequence depend on the history of requests. Only the bench's table and directed scenarios show those.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Vector table entries are four bytes apart.
  localparam int unsigned VEC_STRIDE_SHIFT = 2;
endpackage

// File: rtl/vic_src_latch.sv
module vic_src_latch (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic clr,
  output logic pend
);
  logic line_q;
  logic rise;

  assign rise = line & ~line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      line_q <= line;
      pend   <= (pend & ~clr) | rise;
    end
  end

  // R8: a granted request drops unless a fresh edge arrives together with the grant
  p_clr_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !rise) |=> !pend);
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_BASE = 32,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = $clog2(N_SRC),
  localparam int ADDR_W  = VEC_W + VEC_STRIDE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_line,
  input  logic              glb_en,
  input  logic              mask_we,
  input  logic [N_SRC-1:0]  mask_wdata,
  output logic [N_SRC-1:0]  mask_rdata,
  input  logic              int_ack,
  input  logic              rti,
  output logic              cpu_int,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] mask_eff;
  logic [N_SRC-1:0] gate;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] isr_q;
  logic [N_SRC-1:0] isr_nxt;
  logic             win_found, lvl_found, outranks, grant;
  logic [IDX_W-1:0] win_idx, lvl_idx;
  logic [VEC_W-1:0] num_nxt;

  // one edge-capturing pending latch per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    vic_src_latch u_latch (
      .clk  (clk),
      .rst  (rst),
      .line (irq_line[g]),
      .clr  (clr_vec[g]),
      .pend (pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end
  assign mask_rdata = mask_q;

  always_comb begin
    mask_eff    = mask_q;
    mask_eff[0] = 1'b0;
    gate        = glb_en ? '1 : N_SRC'(1);
  end
  assign elig = pend & ~mask_eff & gate;

  vic_prio_pick #(.N(N_SRC)) u_win (.req(elig),  .found(win_found), .idx(win_idx));
  vic_prio_pick #(.N(N_SRC)) u_lvl (.req(isr_q), .found(lvl_found), .idx(lvl_idx));

  assign outranks = win_found && (!lvl_found || (win_idx < lvl_idx));
  assign grant    = int_ack && outranks;
  assign clr_vec  = grant ? (N_SRC'(1) << win_idx) : '0;
  assign num_nxt  = VEC_W'(VEC_BASE + int'(win_idx));

  always_comb begin
    isr_nxt = isr_q;
    if (rti && lvl_found) isr_nxt[lvl_idx] = 1'b0;
    if (grant)            isr_nxt[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      cpu_int   <= 1'b0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
    end else begin
      isr_q     <= isr_nxt;
      cpu_int   <= outranks;
      vec_valid <= grant;
      if (grant) begin
        vec_num  <= num_nxt;
        vec_addr <= ADDR_W'(num_nxt) << VEC_STRIDE_SHIFT;
      end
    end
  end

  // R11: a vector strobe only ever follows an acknowledge
  p_vec_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(int_ack));
  // R4: the non-maskable source reaches the core unless already in service
  p_nmi_forward_r4: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !isr_q[0]) |=> cpu_int);
  // R5: global enable low silences all ordinary sources
  p_glb_block_r5: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !pend[0]) |=> !cpu_int);
  // R10: a return pulse retires exactly one level
  p_rti_unwind_r10: assert property (@(posedge clk) disable iff (rst)
    (rti && !int_ack && (isr_q != '0)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));
  // R12: mask readback follows the last write
  p_mask_rdback_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_we) && !$past(rst)) |-> (mask_rdata == $past(mask_wdata)));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_line = '0;
  logic       glb_en = 1'b0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] mask_rdata;
  logic       int_ack = 1'b0;
  logic       rti = 1'b0;
  logic       cpu_int, vec_valid;
  logic [7:0] vec_num;
  logic [9:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  vec_irq_ctrl #(.N_SRC(N), .VEC_BASE(32), .VEC_W(8)) u_vec_irq_ctrl (
    .clk(clk), .rst(rst), .irq_line(irq_line), .glb_en(glb_en),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
    .int_ack(int_ack), .rti(rti), .cpu_int(cpu_int), .vec_valid(vec_valid),
    .vec_num(vec_num), .vec_addr(vec_addr)
  );

  always #10 clk = ~clk;

  // {lines, mask, glb_en, expect_int, expect_vector}
  localparam logic [25:0] TBL [0:7] = '{
    {8'h08, 8'h00, 1'b1, 1'b1, 8'd35},  // R7 source 3 -> 35 / 0x08C
    {8'h0C, 8'h00, 1'b1, 1'b1, 8'd34},  // R6 lower index wins
    {8'h0C, 8'h04, 1'b1, 1'b1, 8'd35},  // R3 masked source skipped
    {8'hF0, 8'hF0, 1'b1, 1'b0, 8'd0 },  // R3 all requesters masked
    {8'h81, 8'hFF, 1'b0, 1'b1, 8'd32},  // R4 non-maskable beats mask and enable
    {8'h82, 8'h00, 1'b0, 1'b0, 8'd0 },  // R5 enable low blocks ordinary
    {8'hA0, 8'h20, 1'b1, 1'b1, 8'd39},  // R3 only source 7 passes
    {8'h01, 8'h01, 1'b1, 1'b1, 8'd32}   // R4 mask bit 0 has no effect
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_line = '0; int_ack = 1'b0; rti = 1'b0; mask_we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_wdata = m; mask_we = 1'b1;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    irq_line = p;
    @(negedge clk);
    irq_line = '0;
    @(negedge clk);
  endtask

  task automatic ack();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_expect(input string req, input int vec);
    ack();
    chk(req, int'(vec_valid), 1);
    chk(req, int'(vec_num), vec);
    chk(req, int'(vec_addr), vec * 4);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 cpu_int", int'(cpu_int), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
    chk("R1 mask", int'(mask_rdata), 8'hFF);

    // R12 mask readback
    set_mask(8'h5A);
    chk("R12 mask", int'(mask_rdata), 8'h5A);

    // table walk
    for (int k = 0; k < 8; k++) begin
      logic [25:0] e;
      e = TBL[k];
      do_reset();
      set_mask(e[17:10]);
      glb_en = e[9];
      pulse(e[25:18]);
      chk($sformatf("R9 row%0d cpu_int", k), int'(cpu_int), int'(e[8]));
      ack();
      chk($sformatf("R11 row%0d vec_valid", k), int'(vec_valid), int'(e[8]));
      if (e[8]) begin
        chk($sformatf("R7 row%0d num", k), int'(vec_num), int'(e[7:0]));
        chk($sformatf("R7 row%0d addr", k), int'(vec_addr), int'(e[7:0]) * 4);
      end
    end

    // R7 explicit address for vector 35
    do_reset(); set_mask(8'h00); glb_en = 1'b1;
    pulse(8'h08);
    ack();
    chk("R7 addr 0x08C", int'(vec_addr), 'h8C);

    // R2 level held across acknowledge does not pend again
    do_reset(); set_mask(8'h00); glb_en = 1'b1;
    irq_line = 8'h08;
    @(negedge clk); @(negedge clk);
    ack_expect("R2 held line", 35);
    ret();
    @(negedge clk);
    chk("R2 no re-pend", int'(cpu_int), 0);
    irq_line = '0;

    // R8 grant clears pending
    do_reset(); set_mask(8'h00); glb_en = 1'b1;
    pulse(8'h0A);
    ack_expect("R8 first", 33);
    ret();
    ack_expect("R8 next source", 35);
    ret();
    ack();
    chk("R8 nothing left", int'(vec_valid), 0);

    // R9 / R10 nesting
    do_reset(); set_mask(8'h00); glb_en = 1'b1;
    pulse(8'h20);
    chk("R9 first int", int'(cpu_int), 1);
    ack_expect("R9 first vector", 37);
    pulse(8'h20);
    chk("R9 equal waits", int'(cpu_int), 0);
    pulse(8'h40);
    chk("R9 lower waits", int'(cpu_int), 0);
    pulse(8'h04);
    chk("R9 higher nests", int'(cpu_int), 1);
    ack_expect("R9 nested vector", 34);
    @(negedge clk);
    chk("R9 int drops in nest", int'(cpu_int), 0);
    ret();
    chk("R10 back to level 5", int'(cpu_int), 0);
    ret();
    chk("R10 all retired", int'(cpu_int), 1);
    ack_expect("R6 re-pended 5 first", 37);
    ret();
    ack_expect("R6 then 6", 38);

    finish_run();
  end
endmodule